// File: doc/BRIEF.md
# Context-Encoded Load/Store Access Sequencer

This block sits beside the data-cache pipeline of an in-order core. Every load and store carries a short context field in the top bits of its immediate, placed there by the compiler. The block decodes that field into one of twelve access schedules: eight for loads and four for stores. It then drives one-cycle enable strobes for each cache resource in the four stages EX, DC1, DC2 and DC3. The resources are address generation, all tag arrays, all data arrays, a single data array, the strided-structure tag/index check, the strided-structure data and result formatting.

A nonzero entry number in the context field names an entry of a small strided-access structure. The lookup result for that entry arrives together with the issuing instruction. When the lookup misses, the block does not issue the speculative schedule. It switches to a safer schedule before any array is enabled.

Alongside the strobes, the block presents the following for the instruction currently in EX:
- the entry select;
- the shortened displacement, sign-extended to the address width;
- a flag that marks a zero displacement.

Top module: `ctx_access_seq`

## Requirements
- R1: The immediate is split MSB-first into a 2-bit case code, an ENT_W-bit entry number and an IMM_W-2-ENT_W bit displacement. The displacement is sign-extended to ADDR_W bits on `disp_o`. `disp_zero_o` is high when that displacement is zero. Both describe the instruction in EX, and both read zero when EX is empty.
- R2: Entry number zero selects a non-strided case and nonzero selects a strided case. Load code k selects L(k) when non-strided and L(4+k) when strided. Store code bit 0 selects S0/S1 when non-strided and S2/S3 when strided; store code bit 1 is ignored. `entry_o` carries the entry number for L4–L7, S2 and S3, and is zero otherwise.
- R3: Each strobe vector uses bit 0 for address generation, bit 1 for all tags, bit 2 for all data arrays, bit 3 for one data array, bit 4 for the strided check, bit 5 for strided data and bit 6 for formatting. The non-strided load schedules, by stage, are:
  - L0: EX address generation; DC1 all tags and all data; DC2 formatting.
  - L1: EX all tags and all data; DC1 formatting.
  - L2: EX tags; DC1 one data array; DC2 formatting.
  - L3: EX address generation; DC1 tags; DC2 one data array; DC3 formatting.
- R4: The store schedules never read all data arrays and never format. They are:
  - S0: EX address generation; DC1 tags; DC2 one data array.
  - S1: EX tags; DC1 one data array.
  - S2: EX strided check; DC1 one data array.
  - S3: EX strided check; DC1 one data array plus strided data.
- R5: The strided load schedules are:
  - L4: EX strided check plus one data array; DC1 formatting.
  - L5: EX strided check; DC1 one data array; DC2 formatting.
  - L6: EX strided check, strided data and formatting.
  - L7: EX strided check; DC1 strided data and formatting.
  
  L2, L4–L7, S2 and S3 add address generation in EX exactly when the displacement is nonzero.
- R6: A strided access whose tag/index lookup misses runs the L0 schedule if it is a load and the S0 schedule if it is a store.
- R7: An L6 or L7 access whose tag/index lookup hits but whose word lookup misses runs the L5 schedule. The word lookup has no effect on L4, L5 or stores.
- R8: While `pipe_adv` stays high, an instruction accepted at a clock edge shows its EX strobes in the following cycle and its DCk strobes k cycles after that. Each strobe is a single-cycle pulse.
- R9: A cycle with `pipe_adv` low is followed by a cycle with all strobes low. During such a cycle the occupants hold their stages, and `issue_valid` is ignored.
- R10: While reset is high, all outputs are zero.
- R11: Instructions in different stages drive their own stage vectors in the same cycle, and the vectors do not interfere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_adv | input | 1 | Pipeline advances at this edge |
| issue_valid | input | 1 | A memory instruction enters EX |
| issue_store | input | 1 | The issuing instruction is a store |
| issue_imm | input | IMM_W | Immediate with context field |
| stride_tag_hit | input | 1 | Strided-structure tag/index lookup hit |
| stride_word_hit | input | 1 | Strided-structure word lookup hit |
| act_ex_o | output | 7 | EX stage action strobes |
| act_dc1_o | output | 7 | DC1 stage action strobes |
| act_dc2_o | output | 7 | DC2 stage action strobes |
| act_dc3_o | output | 7 | DC3 stage action strobes |
| entry_o | output | ENT_W | Strided-structure entry of the EX occupant |
| disp_o | output | ADDR_W | Sign-extended displacement of the EX occupant |
| disp_zero_o | output | 1 | EX occupant has a zero displacement |

## Verification
The bench sweeps every combination of the following:
- load or store;
- case code;
- entry number;
- zero, positive or negative displacement;
- both lookup results.

For each combination it follows the strobes through all four stages. This catches a decoder that confuses strided with non-strided, one that reads store code bit 1, and one that falls back from L6/L7 to L0 instead of L5. It also catches a schedule that drops the conditional address generation, or that fires it for a zero displacement. The negative displacement exposes zero-extension.

Two directed sequences cover the pipeline itself. The first overlaps two loads to detect stage crosstalk. The second stalls a store and checks the following:
- that strobes go quiet during the stall, rather than being held or repeated;
- that an instruction offered during the stall is not taken in;
- that the stalled store resumes in DC1.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

  localparam int ACT_W = 7;
  localparam int N_STG = 4;

  localparam int A_AG   = 0;
  localparam int A_TAG  = 1;
  localparam int A_DALL = 2;
  localparam int A_DONE = 3;
  localparam int A_SCHK = 4;
  localparam int A_SDAT = 5;
  localparam int A_FMT  = 6;

  typedef enum logic [3:0] {
    C_L0 = 4'd0, C_L1 = 4'd1, C_L2 = 4'd2,  C_L3 = 4'd3,
    C_L4 = 4'd4, C_L5 = 4'd5, C_L6 = 4'd6,  C_L7 = 4'd7,
    C_S0 = 4'd8, C_S1 = 4'd9, C_S2 = 4'd10, C_S3 = 4'd11
  } acc_case_e;

  // Strobe vector for one case in one stage (0 = EX .. 3 = DC3).
  function automatic logic [ACT_W-1:0] stage_actions(input acc_case_e c,
                                                      input logic nz,
                                                      input int unsigned stg);
    logic [ACT_W-1:0] a;
    a = '0;
    case (c)
      C_L0: case (stg)
              0: a[A_AG] = 1'b1;
              1: begin a[A_TAG] = 1'b1; a[A_DALL] = 1'b1; end
              2: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L1: case (stg)
              0: begin a[A_TAG] = 1'b1; a[A_DALL] = 1'b1; end
              1: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L2: case (stg)
              0: a[A_TAG] = 1'b1;
              1: a[A_DONE] = 1'b1;
              2: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L3: case (stg)
              0: a[A_AG] = 1'b1;
              1: a[A_TAG] = 1'b1;
              2: a[A_DONE] = 1'b1;
              3: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L4: case (stg)
              0: begin a[A_SCHK] = 1'b1; a[A_DONE] = 1'b1; end
              1: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L5: case (stg)
              0: a[A_SCHK] = 1'b1;
              1: a[A_DONE] = 1'b1;
              2: a[A_FMT] = 1'b1;
              default: ;
            endcase
      C_L6: if (stg == 0) begin
              a[A_SCHK] = 1'b1; a[A_SDAT] = 1'b1; a[A_FMT] = 1'b1;
            end
      C_L7: case (stg)
              0: a[A_SCHK] = 1'b1;
              1: begin a[A_SDAT] = 1'b1; a[A_FMT] = 1'b1; end
              default: ;
            endcase
      C_S0: case (stg)
              0: a[A_AG] = 1'b1;
              1: a[A_TAG] = 1'b1;
              2: a[A_DONE] = 1'b1;
              default: ;
            endcase
      C_S1: case (stg)
              0: a[A_TAG] = 1'b1;
              1: a[A_DONE] = 1'b1;
              default: ;
            endcase
      C_S2: case (stg)
              0: a[A_SCHK] = 1'b1;
              1: a[A_DONE] = 1'b1;
              default: ;
            endcase
      C_S3: case (stg)
              0: a[A_SCHK] = 1'b1;
              1: begin a[A_DONE] = 1'b1; a[A_SDAT] = 1'b1; end
              default: ;
            endcase
      default: ;
    endcase
    if (stg == 0 && nz &&
        (c inside {C_L2, C_L4, C_L5, C_L6, C_L7, C_S2, C_S3}))
      a[A_AG] = 1'b1;
    return a;
  endfunction

endpackage

// File: rtl/ctx_decode.sv
module ctx_decode import ctx_seq_pkg::*; #(
  parameter int IMM_W  = 16,
  parameter int ENT_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              is_store,
  input  logic [IMM_W-1:0]  imm,
  input  logic              tag_hit,
  input  logic              word_hit,
  output acc_case_e         case_o,
  output logic [ENT_W-1:0]  ent_o,
  output logic [ADDR_W-1:0] disp_o,
  output logic              nz_o
);
  localparam int DISP_W = IMM_W - 2 - ENT_W;

  logic [1:0]        code;
  logic [ENT_W-1:0]  ent;
  logic [DISP_W-1:0] dsh;
  logic              strided;

  assign code    = imm[IMM_W-1 -: 2];
  assign ent     = imm[IMM_W-3 -: ENT_W];
  assign dsh     = imm[DISP_W-1:0];
  assign strided = |ent;
  assign disp_o  = {{(ADDR_W-DISP_W){dsh[DISP_W-1]}}, dsh};
  assign nz_o    = |dsh;

  always_comb begin
    if (is_store) begin
      if (strided && tag_hit)  case_o = acc_case_e'({3'b101, code[0]});
      else if (strided)        case_o = C_S0;
      else                     case_o = acc_case_e'({3'b100, code[0]});
    end else begin
      if (!strided)                       case_o = acc_case_e'({2'b00, code});
      else if (!tag_hit)                  case_o = C_L0;
      else if (code[1] && !word_hit)      case_o = C_L5;
      else                                case_o = acc_case_e'({2'b01, code});
    end
  end

  always_comb begin
    if (case_o inside {C_L4, C_L5, C_L6, C_L7, C_S2, C_S3}) ent_o = ent;
    else                                                  ent_o = '0;
  end

endmodule

// File: rtl/ctx_stage_pipe.sv
module ctx_stage_pipe import ctx_seq_pkg::*; #(
  parameter int ENT_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         issue,
  input  acc_case_e                    in_case,
  input  logic                         in_nz,
  input  logic [ENT_W-1:0]             in_ent,
  input  logic [ADDR_W-1:0]            in_disp,
  output logic [N_STG-1:0][ACT_W-1:0]  act_o,
  output logic [ENT_W-1:0]             ent_o,
  output logic [ADDR_W-1:0]            disp_o,
  output logic                         dz_o
);
  logic [N_STG-1:0] vld_w;
  logic [N_STG-1:0] nz_w;
  acc_case_e        case_w [N_STG];

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    logic             nxt_vld, nxt_nz, vld_r, nz_r;
    acc_case_e        nxt_case, case_r;
    logic [ACT_W-1:0] act_r;

    if (g == 0) begin : g_head
      assign nxt_vld  = issue;
      assign nxt_case = in_case;
      assign nxt_nz   = in_nz;
    end else begin : g_tail
      assign nxt_vld  = vld_w[g-1];
      assign nxt_case = case_w[g-1];
      assign nxt_nz   = nz_w[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r  <= 1'b0;
        nz_r   <= 1'b0;
        case_r <= C_L0;
        act_r  <= '0;
      end else begin
        act_r <= '0;
        if (adv) begin
          vld_r  <= nxt_vld;
          nz_r   <= nxt_nz;
          case_r <= nxt_case;
          if (nxt_vld) act_r <= stage_actions(nxt_case, nxt_nz, g);
        end
      end
    end

    assign vld_w[g]  = vld_r;
    assign nz_w[g]   = nz_r;
    assign case_w[g] = case_r;
    assign act_o[g]  = act_r;

    assert_strobe_needs_slot_R8: assert property (@(posedge clk) disable iff (rst)
      (act_r != '0) |-> vld_r);
    assert_store_no_fmt_R4: assert property (@(posedge clk) disable iff (rst)
      (act_r[A_DALL] || act_r[A_FMT]) |-> !(case_r inside {C_S0, C_S1, C_S2, C_S3}));
    assert_data_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0({act_r[A_DALL], act_r[A_DONE]}));
    assert_tag_kind_R5: assert property (@(posedge clk) disable iff (rst)
      !(act_r[A_TAG] && act_r[A_SCHK]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_o  <= '0;
      disp_o <= '0;
      dz_o   <= 1'b0;
    end else if (adv) begin
      ent_o  <= issue ? in_ent  : '0;
      disp_o <= issue ? in_disp : '0;
      dz_o   <= issue && !in_nz;
    end
  end

endmodule

// File: rtl/ctx_access_seq.sv
module ctx_access_seq import ctx_seq_pkg::*; #(
  parameter int IMM_W  = 16,
  parameter int ENT_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_adv,
  input  logic              issue_valid,
  input  logic              issue_store,
  input  logic [IMM_W-1:0]  issue_imm,
  input  logic              stride_tag_hit,
  input  logic              stride_word_hit,
  output logic [ACT_W-1:0]  act_ex_o,
  output logic [ACT_W-1:0]  act_dc1_o,
  output logic [ACT_W-1:0]  act_dc2_o,
  output logic [ACT_W-1:0]  act_dc3_o,
  output logic [ENT_W-1:0]  entry_o,
  output logic [ADDR_W-1:0] disp_o,
  output logic              disp_zero_o
);
  acc_case_e                   dec_case;
  logic [ENT_W-1:0]            dec_ent;
  logic [ADDR_W-1:0]           dec_disp;
  logic                        dec_nz;
  logic [N_STG-1:0][ACT_W-1:0] act;

  ctx_decode #(.IMM_W(IMM_W), .ENT_W(ENT_W), .ADDR_W(ADDR_W)) dec_i (
    .is_store (issue_store),
    .imm      (issue_imm),
    .tag_hit  (stride_tag_hit),
    .word_hit (stride_word_hit),
    .case_o   (dec_case),
    .ent_o    (dec_ent),
    .disp_o   (dec_disp),
    .nz_o     (dec_nz)
  );

  ctx_stage_pipe #(.ENT_W(ENT_W), .ADDR_W(ADDR_W)) pipe_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (pipe_adv),
    .issue   (issue_valid),
    .in_case (dec_case),
    .in_nz   (dec_nz),
    .in_ent  (dec_ent),
    .in_disp (dec_disp),
    .act_o   (act),
    .ent_o   (entry_o),
    .disp_o  (disp_o),
    .dz_o    (disp_zero_o)
  );

  assign act_ex_o  = act[0];
  assign act_dc1_o = act[1];
  assign act_dc2_o = act[2];
  assign act_dc3_o = act[3];

  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !pipe_adv |=> (act_ex_o == '0 && act_dc1_o == '0 && act_dc2_o == '0 && act_dc3_o == '0));

endmodule

// File: tb/ctx_access_seq_tb_top.sv
`timescale 1ns/1ps
module ctx_access_seq_tb_top;
  localparam int IMM_W = 16;
  localparam int ENT_W = 2;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_adv = 1'b0, issue_valid = 1'b0, issue_store = 1'b0;
  logic [IMM_W-1:0] issue_imm = '0;
  logic stride_tag_hit = 1'b0, stride_word_hit = 1'b0;
  logic [6:0] act_ex_o, act_dc1_o, act_dc2_o, act_dc3_o;
  logic [ENT_W-1:0] entry_o;
  logic [ADDR_W-1:0] disp_o;
  logic disp_zero_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctx_access_seq #(.IMM_W(IMM_W), .ENT_W(ENT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .pipe_adv(pipe_adv), .issue_valid(issue_valid),
    .issue_store(issue_store), .issue_imm(issue_imm),
    .stride_tag_hit(stride_tag_hit), .stride_word_hit(stride_word_hit),
    .act_ex_o(act_ex_o), .act_dc1_o(act_dc1_o), .act_dc2_o(act_dc2_o),
    .act_dc3_o(act_dc3_o), .entry_o(entry_o), .disp_o(disp_o),
    .disp_zero_o(disp_zero_o)
  );

  task automatic chk(input string tag, input logic [63:0] actual, input logic [63:0] expect_v);
    n_chk++;
    if (actual !== expect_v) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expect_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [27:0] acts();
    return {act_ex_o, act_dc1_o, act_dc2_o, act_dc3_o};
  endfunction

  function automatic logic [27:0] place(input int s, input logic [6:0] v);
    logic [27:0] r;
    r = '0;
    r[(3-s)*7 +: 7] = v;
    return r;
  endfunction

  // Effective case per R2, R6, R7: 0..7 loads L0..L7, 8..11 stores S0..S3.
  function automatic int eff_case(input bit st, input int code, input int ent,
                                  input bit th, input bit wh);
    if (st) begin
      if (ent != 0 && th) return 10 + (code & 1);
      if (ent != 0) return 8;
      return 8 + (code & 1);
    end
    if (ent == 0) return code;
    if (!th) return 0;
    if (code >= 2 && !wh) return 5;
    return 4 + code;
  endfunction

  // Stage strobes per R3, R4, R5 (bit weights AG 1, TAG 2, DALL 4, DONE 8, SCHK 16, SDAT 32, FMT 64).
  function automatic logic [6:0] exp_act(input int ec, input bit nz, input int stg);
    int r;
    r = 0;
    case (ec)
      0:  r = (stg == 0) ? 1  : (stg == 1) ? 6  : (stg == 2) ? 64 : 0;
      1:  r = (stg == 0) ? 6  : (stg == 1) ? 64 : 0;
      2:  r = (stg == 0) ? 2  : (stg == 1) ? 8  : (stg == 2) ? 64 : 0;
      3:  r = (stg == 0) ? 1  : (stg == 1) ? 2  : (stg == 2) ? 8  : (stg == 3) ? 64 : 0;
      4:  r = (stg == 0) ? 24 : (stg == 1) ? 64 : 0;
      5:  r = (stg == 0) ? 16 : (stg == 1) ? 8  : (stg == 2) ? 64 : 0;
      6:  r = (stg == 0) ? 112 : 0;
      7:  r = (stg == 0) ? 16 : (stg == 1) ? 96 : 0;
      8:  r = (stg == 0) ? 1  : (stg == 1) ? 2  : (stg == 2) ? 8  : 0;
      9:  r = (stg == 0) ? 2  : (stg == 1) ? 8  : 0;
      10: r = (stg == 0) ? 16 : (stg == 1) ? 8  : 0;
      11: r = (stg == 0) ? 16 : (stg == 1) ? 40 : 0;
      default: r = 0;
    endcase
    if (stg == 0 && nz && (ec inside {2, 4, 5, 6, 7, 10, 11})) r = r | 1;
    return r[6:0];
  endfunction

  function automatic logic [15:0] mk_imm(input int code, input int ent, input int dv);
    logic [31:0] d;
    d = dv;
    return {code[1:0], ent[1:0], d[11:0]};
  endfunction

  initial begin
    // R10: reset holds everything at zero even with issue offered
    pipe_adv = 1'b1; issue_valid = 1'b1; issue_imm = mk_imm(1, 0, 0);
    step(); step();
    chk("R10 strobes", {36'd0, acts()}, 64'd0);
    chk("R10 ex fields", {31'd0, disp_zero_o, disp_o}, 64'd0);
    chk("R10 entry", {62'd0, entry_o}, 64'd0);
    issue_valid = 1'b0;
    rst = 1'b0;
    step();

    // Sweep over kind, code, entry, displacement and both lookup results
    for (int st = 0; st < 2; st++)
      for (int code = 0; code < 4; code++)
        for (int ent = 0; ent < 4; ent++)
          for (int ds = 0; ds < 3; ds++)
            for (int th = 0; th < 2; th++)
              for (int wh = 0; wh < 2; wh++) begin
                int dv, ec, exp_ent;
                bit nz;
                string tg;
                dv = (ds == 0) ? 0 : (ds == 1) ? 5 : -3;
                nz = (dv != 0);
                ec = eff_case(st[0], code, ent, th[0], wh[0]);
                exp_ent = (ec inside {4, 5, 6, 7, 10, 11}) ? ent : 0;
                if (st != 0) tg = (ent != 0 && th == 0) ? "R6" : "R4";
                else if (ent == 0) tg = "R3";
                else if (th == 0) tg = "R6";
                else if (code >= 2 && wh == 0) tg = "R7";
                else tg = "R5";
                tg = $sformatf("%s st=%0d code=%0d ent=%0d d=%0d th=%0d wh=%0d",
                               tg, st, code, ent, dv, th, wh);
                issue_store = st[0]; issue_imm = mk_imm(code, ent, dv);
                stride_tag_hit = th[0]; stride_word_hit = wh[0];
                issue_valid = 1'b1; pipe_adv = 1'b1;
                step();
                issue_valid = 1'b0;
                chk({tg, " EX"}, {36'd0, acts()}, {36'd0, place(0, exp_act(ec, nz, 0))});
                chk({"R1 disp ", tg}, {31'd0, disp_zero_o, disp_o},
                    {31'd0, !nz, 32'(dv)});
                chk({"R2 entry ", tg}, {62'd0, entry_o}, 64'(exp_ent));
                for (int s = 1; s < 4; s++) begin
                  step();
                  chk($sformatf("%s R8 stage %0d", tg, s), {36'd0, acts()},
                      {36'd0, place(s, exp_act(ec, nz, s))});
                end
              end
    step();

    // R11: L3 (disp 5) followed by L1 (disp 0) back to back
    issue_store = 1'b0; stride_tag_hit = 1'b0; stride_word_hit = 1'b0;
    issue_imm = mk_imm(3, 0, 5); issue_valid = 1'b1;
    step();
    chk("R11 c1", {36'd0, acts()}, {36'd0, place(0, exp_act(3, 1, 0))});
    issue_imm = mk_imm(1, 0, 0);
    step();
    issue_valid = 1'b0;
    chk("R11 c2", {36'd0, acts()},
        {36'd0, place(0, exp_act(1, 0, 0)) | place(1, exp_act(3, 1, 1))});
    step();
    chk("R11 c3", {36'd0, acts()},
        {36'd0, place(1, exp_act(1, 0, 1)) | place(2, exp_act(3, 1, 2))});
    step();
    chk("R11 c4", {36'd0, acts()}, {36'd0, place(3, exp_act(3, 1, 3))});
    step(); step();

    // R9: S0 with disp 5, then two stalled cycles offering another instruction
    issue_store = 1'b1; issue_imm = mk_imm(0, 0, 5); issue_valid = 1'b1;
    step();
    chk("R9 ex", {36'd0, acts()}, {36'd0, place(0, 7'd1)});
    pipe_adv = 1'b0; issue_store = 1'b0; issue_imm = mk_imm(1, 0, 7);
    step();
    chk("R9 stall1 strobes", {36'd0, acts()}, 64'd0);
    chk("R9 stall1 held disp", {32'd0, disp_o}, 64'd5);
    step();
    chk("R9 stall2 strobes", {36'd0, acts()}, 64'd0);
    issue_valid = 1'b0; pipe_adv = 1'b1;
    step();
    chk("R9 resume dc1", {36'd0, acts()}, {36'd0, place(1, 7'd2)});
    step();
    chk("R9 resume dc2", {36'd0, acts()}, {36'd0, place(2, 7'd8)});
    step();
    chk("R9 drained", {36'd0, acts()}, 64'd0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule